// File: doc/BRIEF.md
# Segmented Address Decoder With Cache Isolation

This block sits on the request side of a 32-bit CPU bus and works out, for every access, which target it reaches and where inside that target it lands. Main RAM, the boot ROM, a small scratchpad, the I/O page and a single cache-control register each have one or more mirrored address windows. The decoder names the target, raises exactly one select line for a serviced access, and hands the target its local byte offset. Reads of an address no target owns are flagged for a zero answer, and writes there are flagged as discarded.

One piece of state lives inside: a RAM write-isolation flag. Writing certain values to the cache-control register turns RAM writes off, so that the CPU can run with its cache detached from memory. Writing one of the release values turns them back on. While isolated, RAM reads keep working; only RAM writes are suppressed. All decode is combinational; the flag changes on the clock edge that accepts the control write.

Top module: `seg_addr_decoder`

## Requirements
- R1: RAM (target code 1) answers in the 8 MB windows starting at 0x00000000, 0x80000000 and 0xA0000000; the 2 MB RAM repeats four times in each window, so the local offset is address bits 20:0.
- R2: Boot ROM (target code 2) answers in the 512 KB windows at 0x1FC00000 and 0xBFC00000 with local offset address bits 18:0; it is read-only, so a write to it raises no select and is reported as dropped.
- R3: The 4 KB scratchpad (target code 3) answers at 0x1F800000 and 0x9F800000 only, local offset bits 11:0; the page at 0xBF800000 is unmapped.
- R4: The 4 KB I/O page (target code 4) answers at 0x1F801000, 0x9F801000 and 0xBF801000, local offset bits 11:0, for reads and writes.
- R5: A write of 0x800 or 0x804 to the control register at 0xFFFE0130 sets the isolation flag from the next clock edge.
- R6: A write of 0x0 or 0x1E988 to 0xFFFE0130 clears the isolation flag from the next clock edge.
- R7: Any other value written to 0xFFFE0130 leaves the flag unchanged; writes elsewhere in the page 0xFFFE0000-0xFFFE0FFF (target code 5) leave it unchanged and are reported as dropped, while a write to the register itself is not reported as dropped.
- R8: While isolated, a RAM write raises no RAM select and is reported as dropped; RAM reads still raise the RAM select.
- R9: An access to no target has target code 0; a read of it, or a read anywhere in the control page, raises the zero-read flag and no select; a write to an unmapped address is reported as dropped and changes nothing.
- R10: Reset clears the isolation flag; with no valid request no select, zero-read or dropped flag is raised and the flag does not change.
- R11: At most one select is high at a time, and the local offset is zero whenever the target code is 0 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data (used only by the control register) |
| tgt_code | output | 3 | Decoded target: 0 none, 1 RAM, 2 ROM, 3 scratchpad, 4 I/O, 5 control page |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select (reads only) |
| sel_spad | output | 1 | Scratchpad select |
| sel_io | output | 1 | I/O page select |
| local_off | output | 21 | Byte offset inside the selected target |
| rd_zero | output | 1 | Read must return zero |
| wr_drop | output | 1 | Write is discarded |
| ram_wr_isolated | output | 1 | RAM writes are currently blocked |

## Verification
The bench aims at mirror edges: the last word of each 8 MB RAM window (a decoder that compared too few upper bits would alias 0x00800000 into RAM, one that compared too many would miss the upper mirrors) and the page just above the scratchpad, which is I/O. It checks the uncached scratchpad hole at 0xBF800000, where a decoder copying the I/O mirror list would wrongly answer. Control writes at the exact register with each set, release and unrelated value, and at a neighbouring word in the same page, expose a flag that toggles on any value or on any page address. Isolated RAM reads are checked separately from writes, since a design that gated the whole RAM select would starve reads.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Bus geometry
    localparam int ADDR_W       = 32;
    localparam int DATA_W       = 32;
    localparam int PAGE_LOG2    = 12;
    localparam int RAM_LOG2     = 21;
    localparam int RAM_WIN_LOG2 = 23;
    localparam int ROM_LOG2     = 19;
    localparam int OFF_W        = RAM_LOG2;

    // Widths of the compared upper address slices
    localparam int RAM_MW = ADDR_W - RAM_WIN_LOG2;
    localparam int ROM_MW = ADDR_W - ROM_LOG2;
    localparam int PG_MW  = ADDR_W - PAGE_LOG2;

    // Mirror counts
    localparam int RAM_NB  = 3;
    localparam int ROM_NB  = 2;
    localparam int SPAD_NB = 2;
    localparam int IO_NB   = 3;
    localparam int CC_NB   = 1;

    localparam logic [ADDR_W-1:0] CCTL_ADDR = 32'hFFFE_0130;
    localparam logic [PAGE_LOG2-1:0] CCTL_OFF = CCTL_ADDR[PAGE_LOG2-1:0];

    localparam logic [RAM_NB-1:0][RAM_MW-1:0] RAM_BASES = {
        RAM_MW'(32'hA000_0000 >> RAM_WIN_LOG2),
        RAM_MW'(32'h8000_0000 >> RAM_WIN_LOG2),
        RAM_MW'(32'h0000_0000 >> RAM_WIN_LOG2)
    };
    localparam logic [ROM_NB-1:0][ROM_MW-1:0] ROM_BASES = {
        ROM_MW'(32'hBFC0_0000 >> ROM_LOG2),
        ROM_MW'(32'h1FC0_0000 >> ROM_LOG2)
    };
    localparam logic [SPAD_NB-1:0][PG_MW-1:0] SPAD_BASES = {
        PG_MW'(32'h9F80_0000 >> PAGE_LOG2),
        PG_MW'(32'h1F80_0000 >> PAGE_LOG2)
    };
    localparam logic [IO_NB-1:0][PG_MW-1:0] IO_BASES = {
        PG_MW'(32'hBF80_1000 >> PAGE_LOG2),
        PG_MW'(32'h9F80_1000 >> PAGE_LOG2),
        PG_MW'(32'h1F80_1000 >> PAGE_LOG2)
    };
    localparam logic [CC_NB-1:0][PG_MW-1:0] CC_BASES = {
        PG_MW'(CCTL_ADDR >> PAGE_LOG2)
    };

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_ROM  = 3'd2,
        TGT_SPAD = 3'd3,
        TGT_IO   = 3'd4,
        TGT_CCTL = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        CC_KEEP    = 2'd0,
        CC_ISOLATE = 2'd1,
        CC_RELEASE = 2'd2
    } cc_act_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [OFF_W-1:0] off;
        logic             exact_ctl;
    } dec_t;

    // Map a control-register write value to its effect on isolation
    function automatic cc_act_e cc_classify(input logic [DATA_W-1:0] v);
        cc_act_e a;
        case (v)
            32'h0000_0800, 32'h0000_0804: a = CC_ISOLATE;
            32'h0000_0000, 32'h0001_E988: a = CC_RELEASE;
            default:                      a = CC_KEEP;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sad_region_match.sv
module sad_region_match #(
    parameter int NB = 1,
    parameter int MW = 20,
    parameter int LW = 12,
    parameter int OW = 21,
    parameter logic [NB-1:0][MW-1:0] BASES = '0
) (
    input  logic [sad_pkg::ADDR_W-1:0] addr,
    output logic                       hit,
    output logic [OW-1:0]              off
);
    localparam int AW = sad_pkg::ADDR_W;

    logic [NB-1:0] hit_vec;

    for (genvar g = 0; g < NB; g++) begin : g_mirror
        assign hit_vec[g] = (addr[AW-1 -: MW] == BASES[g]);
    end

    assign hit = |hit_vec;
    assign off = OW'(addr[LW-1:0]);

    logic unused_addr;
    assign unused_addr = ^addr;
endmodule

// File: rtl/sad_isolation_ctl.sv
module sad_isolation_ctl
    import sad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_data,
    output logic              isolated
);
    cc_act_e act;

    always_comb begin
        act = ctl_wr ? cc_classify(ctl_data) : CC_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isolated <= 1'b0;
        end else begin
            case (act)
                CC_ISOLATE: isolated <= 1'b1;
                CC_RELEASE: isolated <= 1'b0;
                default:    isolated <= isolated;
            endcase
        end
    end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
    import sad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [2:0]        tgt_code,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_spad,
    output logic              sel_io,
    output logic [OFF_W-1:0]  local_off,
    output logic              rd_zero,
    output logic              wr_drop,
    output logic              ram_wr_isolated
);
    logic             ram_hit, rom_hit, spad_hit, io_hit, cc_hit;
    logic [OFF_W-1:0] ram_off, rom_off, spad_off, io_off, cc_off;
    dec_t             dec;
    logic             is_rd, is_wr, ctl_wr, iso_q;

    sad_region_match #(.NB(RAM_NB), .MW(RAM_MW), .LW(RAM_LOG2), .OW(OFF_W),
                       .BASES(RAM_BASES))
        u_ram  (.addr(req_addr), .hit(ram_hit),  .off(ram_off));
    sad_region_match #(.NB(ROM_NB), .MW(ROM_MW), .LW(ROM_LOG2), .OW(OFF_W),
                       .BASES(ROM_BASES))
        u_rom  (.addr(req_addr), .hit(rom_hit),  .off(rom_off));
    sad_region_match #(.NB(SPAD_NB), .MW(PG_MW), .LW(PAGE_LOG2), .OW(OFF_W),
                       .BASES(SPAD_BASES))
        u_spad (.addr(req_addr), .hit(spad_hit), .off(spad_off));
    sad_region_match #(.NB(IO_NB), .MW(PG_MW), .LW(PAGE_LOG2), .OW(OFF_W),
                       .BASES(IO_BASES))
        u_io   (.addr(req_addr), .hit(io_hit),   .off(io_off));
    sad_region_match #(.NB(CC_NB), .MW(PG_MW), .LW(PAGE_LOG2), .OW(OFF_W),
                       .BASES(CC_BASES))
        u_cc   (.addr(req_addr), .hit(cc_hit),   .off(cc_off));

    // Windows are disjoint, so the order below only fixes a structure
    always_comb begin
        dec = '{tgt: TGT_NONE, off: '0, exact_ctl: 1'b0};
        if (ram_hit) begin
            dec.tgt = TGT_RAM;
            dec.off = ram_off;
        end else if (rom_hit) begin
            dec.tgt = TGT_ROM;
            dec.off = rom_off;
        end else if (spad_hit) begin
            dec.tgt = TGT_SPAD;
            dec.off = spad_off;
        end else if (io_hit) begin
            dec.tgt = TGT_IO;
            dec.off = io_off;
        end else if (cc_hit) begin
            dec.tgt       = TGT_CCTL;
            dec.exact_ctl = (cc_off[PAGE_LOG2-1:0] == CCTL_OFF);
        end
    end

    assign is_rd  = req_valid & ~req_we;
    assign is_wr  = req_valid &  req_we;
    assign ctl_wr = is_wr & (dec.tgt == TGT_CCTL) & dec.exact_ctl;

    sad_isolation_ctl u_iso (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_data (req_wdata),
        .isolated (iso_q)
    );

    always_comb begin
        sel_ram  = req_valid & (dec.tgt == TGT_RAM) & ~(req_we & iso_q);
        sel_rom  = is_rd & (dec.tgt == TGT_ROM);
        sel_spad = req_valid & (dec.tgt == TGT_SPAD);
        sel_io   = req_valid & (dec.tgt == TGT_IO);
        rd_zero  = is_rd & ((dec.tgt == TGT_NONE) | (dec.tgt == TGT_CCTL));
        wr_drop  = is_wr & ((dec.tgt == TGT_NONE)
                          | (dec.tgt == TGT_ROM)
                          | ((dec.tgt == TGT_RAM) & iso_q)
                          | ((dec.tgt == TGT_CCTL) & ~dec.exact_ctl));
    end

    assign tgt_code        = dec.tgt;
    assign local_off       = dec.off;
    assign ram_wr_isolated = iso_q;
endmodule

// File: rtl/seg_addr_decoder_chk.sv
module seg_addr_decoder_chk
    import sad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [2:0]        tgt_code,
    input logic              sel_ram,
    input logic              sel_rom,
    input logic              sel_spad,
    input logic              sel_io,
    input logic              rd_zero,
    input logic              wr_drop,
    input logic              ram_wr_isolated
);
    logic cc_wr_here, set_val, clr_val;
    assign cc_wr_here = req_valid && req_we && (req_addr == CCTL_ADDR);
    assign set_val = (req_wdata == 32'h800) || (req_wdata == 32'h804);
    assign clr_val = (req_wdata == 32'h0) || (req_wdata == 32'h1E988);

    assert_one_sel_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ram, sel_rom, sel_spad, sel_io}));

    assert_iso_set_R5: assert property (@(posedge clk) disable iff (rst)
        (cc_wr_here && set_val) |=> ram_wr_isolated);

    assert_iso_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (cc_wr_here && clr_val) |=> !ram_wr_isolated);

    assert_iso_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(cc_wr_here && (set_val || clr_val)) |=> $stable(ram_wr_isolated));

    assert_ram_wr_block_R8: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_isolated && req_valid && req_we) |-> !sel_ram);

    assert_rom_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we && tgt_code == 3'd2) |-> (!sel_rom && wr_drop));

    assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && tgt_code == 3'd0)
            |-> (rd_zero && !sel_ram && !sel_rom && !sel_spad && !sel_io));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(sel_ram || sel_rom || sel_spad || sel_io
                         || rd_zero || wr_drop));
endmodule

bind seg_addr_decoder seg_addr_decoder_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_we          (req_we),
    .req_addr        (req_addr),
    .req_wdata       (req_wdata),
    .tgt_code        (tgt_code),
    .sel_ram         (sel_ram),
    .sel_rom         (sel_rom),
    .sel_spad        (sel_spad),
    .sel_io          (sel_io),
    .rd_zero         (rd_zero),
    .wr_drop         (wr_drop),
    .ram_wr_isolated (ram_wr_isolated)
);

// File: tb/seg_addr_decoder_tb.sv
module seg_addr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  tgt_code;
    logic        sel_ram, sel_rom, sel_spad, sel_io;
    logic [20:0] local_off;
    logic        rd_zero, wr_drop, ram_wr_isolated;

    int n_checks = 0;
    int n_fail   = 0;
    bit iso_m    = 1'b0;
    bit done     = 1'b0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    seg_addr_decoder u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .tgt_code(tgt_code),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_spad(sel_spad),
        .sel_io(sel_io), .local_off(local_off), .rd_zero(rd_zero),
        .wr_drop(wr_drop), .ram_wr_isolated(ram_wr_isolated)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: expected target from address ranges
    function automatic int ref_tgt(input logic [31:0] a);
        if ((a < 32'h0080_0000) ||
            (a >= 32'h8000_0000 && a < 32'h8080_0000) ||
            (a >= 32'hA000_0000 && a < 32'hA080_0000)) return 1;
        if ((a >= 32'h1FC0_0000 && a < 32'h1FC8_0000) ||
            (a >= 32'hBFC0_0000 && a < 32'hBFC8_0000)) return 2;
        if ((a >= 32'h1F80_0000 && a < 32'h1F80_1000) ||
            (a >= 32'h9F80_0000 && a < 32'h9F80_1000)) return 3;
        if ((a >= 32'h1F80_1000 && a < 32'h1F80_2000) ||
            (a >= 32'h9F80_1000 && a < 32'h9F80_2000) ||
            (a >= 32'hBF80_1000 && a < 32'hBF80_2000)) return 4;
        if (a >= 32'hFFFE_0000 && a < 32'hFFFE_1000) return 5;
        return 0;
    endfunction

    function automatic logic [31:0] ref_off(input logic [31:0] a, input int t);
        case (t)
            1: return a % 32'h0020_0000;
            2: return a % 32'h0008_0000;
            3, 4: return a % 32'h0000_1000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int t, input bit we, input bit v);
        if (!v) return "R10";
        case (t)
            1: return (we && iso_m) ? "R8" : "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Drive at the falling edge, check outputs 1 ns later, then let the
    // rising edge commit the request and update the model.
    task automatic do_req(input bit v, input bit we, input logic [31:0] a,
                          input logic [31:0] d);
        int t;
        string tg;
        logic [3:0] sel_e;
        bit rz, wd;
        @(negedge clk);
        req_valid = v; req_we = we; req_addr = a; req_wdata = d;
        #1;
        t  = ref_tgt(a);
        tg = tag_of(t, we, v);
        sel_e = '0;
        if (v) begin
            sel_e[0] = (t == 1) && !(we && iso_m);
            sel_e[1] = (t == 2) && !we;
            sel_e[2] = (t == 3);
            sel_e[3] = (t == 4);
        end
        rz = v && !we && (t == 0 || t == 5);
        wd = v && we && (t == 0 || t == 2 || (t == 1 && iso_m) ||
                         (t == 5 && a != 32'hFFFE_0130));
        chk(tg, "tgt_code", 32'(tgt_code), 32'(t));
        chk(tg, "local_off", 32'(local_off), ref_off(a, t));
        chk(tg, "selects", 32'({sel_io, sel_spad, sel_rom, sel_ram}), 32'(sel_e));
        chk(tg, "rd_zero", 32'(rd_zero), 32'(rz));
        chk(tg, "wr_drop", 32'(wr_drop), 32'(wd));
        chk("R11", "select count", 32'($countones({sel_io, sel_spad, sel_rom, sel_ram}) <= 1), 32'd1);
        @(posedge clk);
        if (v && we && a == 32'hFFFE_0130) begin
            if (d == 32'h800 || d == 32'h804) iso_m = 1'b1;
            else if (d == 32'h0 || d == 32'h1E988) iso_m = 1'b0;
        end
        #1;
        if (v && we && a == 32'hFFFE_0130) begin
            if (d == 32'h800 || d == 32'h804) tg = "R5";
            else if (d == 32'h0 || d == 32'h1E988) tg = "R6";
            else tg = "R7";
        end
        chk(tg, "isolated", 32'(ram_wr_isolated), 32'(iso_m));
    endtask

    function automatic logic [31:0] rand_addr();
        logic [31:0] r = $urandom;
        case ($urandom % 8)
            0: return (($urandom % 3) == 0 ? 32'h0 : (($urandom % 2) ? 32'h8000_0000 : 32'hA000_0000)) + (r & 32'h7F_FFFC);
            1: return (($urandom % 2) ? 32'h1FC0_0000 : 32'hBFC0_0000) + (r & 32'h7_FFFF);
            2: return (($urandom % 2) ? 32'h1F80_0000 : 32'h9F80_0000) + (r & 32'hFFF);
            3: return (($urandom % 3) == 0 ? 32'h1F80_1000 : (($urandom % 2) ? 32'h9F80_1000 : 32'hBF80_1000)) + (r & 32'hFFF);
            4: return (($urandom % 2) ? 32'hFFFE_0130 : 32'hFFFE_0000 + (r & 32'hFFC));
            5: return 32'hBF80_0000 + (r & 32'hFFF);
            default: return r;
        endcase
    endfunction

    function automatic logic [31:0] rand_data();
        case ($urandom % 6)
            0: return 32'h800;
            1: return 32'h804;
            2: return 32'h0;
            3: return 32'h1E988;
            default: return $urandom;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "isolated after reset", 32'(ram_wr_isolated), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed corner cases
        do_req(0, 1, 32'hFFFE_0130, 32'h800);   // R10: idle, no state change
        do_req(1, 0, 32'hA07F_FFFC, 0);         // R1 top of uncached window
        do_req(1, 1, 32'h0080_0000, 0);         // R9 just past RAM window
        do_req(1, 0, 32'hBF80_0010, 0);         // R3 hole: unmapped
        do_req(1, 1, 32'h1F80_1FFC, 0);         // R4 last I/O word
        do_req(1, 1, 32'h1FC0_0040, 0);         // R2 ROM write dropped
        do_req(1, 1, 32'hFFFE_0130, 32'h800);   // R5 isolate
        do_req(1, 1, 32'h8012_3450, 32'h55);    // R8 write blocked
        do_req(1, 0, 32'h8012_3450, 0);         // R8 read still served
        do_req(1, 1, 32'hFFFE_0130, 32'h12345); // R7 keep
        do_req(1, 1, 32'hFFFE_0134, 32'h0);     // R7 other page word ignored
        do_req(1, 0, 32'hFFFE_0130, 0);         // R9 control page read zero
        do_req(1, 1, 32'hFFFE_0130, 32'h1E988); // R6 release
        do_req(1, 1, 32'h0000_1000, 32'h1);     // R1 write allowed again
        do_req(1, 1, 32'hFFFE_0130, 32'h804);   // R5 second set value
        do_req(1, 1, 32'hFFFE_0130, 32'h0);     // R6 second release value

        for (int i = 0; i < 600; i++) begin
            do_req(($urandom % 8) != 0, $urandom % 2, rand_addr(), rand_data());
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule